// File: doc/BRIEF.md
# Sequenced SIMD Lane Engine

This block runs a packed SIMD operation (one, two or four lanes) through a single shared arithmetic pipeline. It does not replicate the datapath for each lane. When a start request is accepted, the block captures both packed operand vectors. It then feeds the lanes into the pipeline on consecutive cycles, lowest lane first, and collects each lane result in its own slice of a packed result word. A scalar operation is the one-lane case and takes the same path.

The pipeline is five stages deep and performs a per-lane wrap-around add or a low-half multiply. The lanes overlap inside the pipeline, so each extra lane adds one cycle to the total latency. A multi-lane operation also spends one final cycle moving the gathered word to the output. While an operation is in flight the block reports busy and ignores further start requests. The caller waits for the done pulse and then takes the packed result.

Top module: `simd_lane_seq`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all zero.
- R2: Lane i of each operand is the slice [16*i +: 16]. Opcode 0 writes (a_i + b_i) mod 2^16 into result lane i. Opcode 1 writes the low 16 bits of a_i * b_i.
- R3: Width select 0 gives one lane, 1 gives two lanes, and 2 or 3 gives four lanes. Result lanes at or above the lane count read zero at done.
- R4: A start is accepted when start_i is high at a rising edge while busy_o is low. done_o is then high in the cycle that follows the 6th (one lane), 8th (two lanes) or 10th (four lanes) rising edge after the accepting edge.
- R5: done_o is high for exactly one cycle per accepted operation. result_o holds its value until the next operation's done.
- R6: busy_o is high from the cycle after the accepting edge through the done cycle, and is low in the cycle after done.
- R7: A start request while busy_o is high, including in the done cycle, is ignored. It changes neither the running operation's result nor its timing, and produces no extra done.
- R8: A start presented in the first cycle after done (busy_o low) is accepted at once.
- R9: Lanes enter the pipeline on consecutive cycles in ascending order and leave it in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 1 | 0 = add, 1 = multiply (low half) |
| wsel_i | input | 2 | Lane count select: 0 = 1, 1 = 2, 2 or 3 = 4 |
| a_i | input | 64 | Packed first operand, four 16-bit lanes |
| b_i | input | 64 | Packed second operand, four 16-bit lanes |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | 64 | Packed lane results |

## Verification
Two functions can coincide in one cycle: completion of the running operation and a new start request. The bench drives start_i high in the exact cycle in which done_o is seen. It then checks that busy_o and done_o are both low in the next cycle and that no further done appears. A later start, placed in the first cycle after done, must be accepted with the normal latency. Start requests injected in the middle of an operation are judged the same way: the running operation must still meet its exact cycle count and lane-wise result.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } lane_op_e;

  // Number of lanes selected by a width code; codes at or past log_max saturate.
  function automatic int unsigned lanes_for(input int unsigned wsel,
                                            input int unsigned log_max);
    if (wsel >= log_max) return (1 << log_max);
    return (1 << wsel);
  endfunction

  // Cycles from accepting edge to done: setup + pipe + extra lanes + gather step.
  function automatic int unsigned seq_latency(input int unsigned nl,
                                              input int unsigned pipe);
    return 1 + pipe + (nl - 1) + ((nl > 1) ? 1 : 0);
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned MAX_LANES = 4,
  parameter int unsigned WSEL_W    = 2,
  localparam int unsigned VW  = LANE_W * MAX_LANES,
  localparam int unsigned LIW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int unsigned LCW = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [VW-1:0]     a_i,
  input  logic [VW-1:0]     b_i,
  input  logic              done_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [LCW-1:0]    nl_o,
  output logic              iss_vld_o,
  output logic [LIW-1:0]    iss_lane_o,
  output logic              iss_op_o,
  output logic [LANE_W-1:0] iss_a_o,
  output logic [LANE_W-1:0] iss_b_o
);
  import simd_seq_pkg::*;

  localparam int unsigned LOG_MAX = $clog2(MAX_LANES);

  logic              busy_q, issuing_q, op_q;
  logic [LIW-1:0]    idx_q;
  logic [LCW-1:0]    nl_q;
  logic [VW-1:0]     a_q, b_q;
  logic              last_issue;

  assign accept_o   = start_i && !busy_q;
  assign last_issue = issuing_q && (LCW'(idx_q) == nl_q - LCW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      issuing_q <= 1'b0;
      op_q      <= 1'b0;
      idx_q     <= '0;
      nl_q      <= LCW'(1);
      a_q       <= '0;
      b_q       <= '0;
    end else if (accept_o) begin
      busy_q    <= 1'b1;
      issuing_q <= 1'b1;
      op_q      <= op_i;
      idx_q     <= '0;
      nl_q      <= LCW'(lanes_for(int'(wsel_i), LOG_MAX));
      a_q       <= a_i;
      b_q       <= b_i;
    end else begin
      if (done_i) busy_q <= 1'b0;
      if (issuing_q) begin
        idx_q <= idx_q + LIW'(1);
        if (last_issue) issuing_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign nl_o       = nl_q;
  assign iss_vld_o  = issuing_q;
  assign iss_lane_o = idx_q;
  assign iss_op_o   = op_q;
  assign iss_a_o    = a_q[idx_q*LANE_W +: LANE_W];
  assign iss_b_o    = b_q[idx_q*LANE_W +: LANE_W];

  // R7: captured operands cannot move while an operation is in flight
  a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(a_q) && $stable(b_q) && $stable(op_q) && $stable(nl_q)));

  // R6: busy only drops right after a done cycle
  a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done_i));

  // R9: lanes after lane 0 follow the previous lane with no gap
  a_r9_issue_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld_o && idx_q != '0) |-> ($past(iss_vld_o) && $past(idx_q) == idx_q - LIW'(1)));

endmodule

// File: rtl/lane_pipe.sv
module lane_pipe #(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned MAX_LANES = 4,
  parameter int unsigned PIPE      = 5,
  localparam int unsigned LIW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [LIW-1:0]    in_lane,
  input  logic              in_op,
  input  logic [LANE_W-1:0] in_a,
  input  logic [LANE_W-1:0] in_b,
  output logic              out_vld,
  output logic [LIW-1:0]    out_lane,
  output logic [LANE_W-1:0] out_val
);
  import simd_seq_pkg::*;

  function automatic logic [LANE_W-1:0] lane_calc(input logic mul,
                                                  input logic [LANE_W-1:0] x,
                                                  input logic [LANE_W-1:0] y);
    logic [2*LANE_W-1:0] prod;
    prod = {{LANE_W{1'b0}}, x} * {{LANE_W{1'b0}}, y};
    if (lane_op_e'(mul) == OP_MUL) return prod[LANE_W-1:0];
    return x + y;
  endfunction

  logic              vld_q  [PIPE];
  logic [LIW-1:0]    lane_q [PIPE];
  logic [LANE_W-1:0] val_q  [PIPE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0]  <= 1'b0;
      lane_q[0] <= '0;
      val_q[0]  <= '0;
    end else begin
      vld_q[0]  <= in_vld;
      lane_q[0] <= in_lane;
      val_q[0]  <= lane_calc(in_op, in_a, in_b);
    end
  end

  for (genvar s = 1; s < PIPE; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s]  <= 1'b0;
        lane_q[s] <= '0;
        val_q[s]  <= '0;
      end else begin
        vld_q[s]  <= vld_q[s-1];
        lane_q[s] <= lane_q[s-1];
        val_q[s]  <= val_q[s-1];
      end
    end
  end

  assign out_vld  = vld_q[PIPE-1];
  assign out_lane = lane_q[PIPE-1];
  assign out_val  = val_q[PIPE-1];

  // R9: results leave the pipe in ascending lane order on consecutive cycles
  a_r9_exit_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_lane != '0) |-> ($past(out_vld) && $past(out_lane) == out_lane - LIW'(1)));

endmodule

// File: rtl/lane_gather.sv
module lane_gather #(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned MAX_LANES = 4,
  localparam int unsigned VW  = LANE_W * MAX_LANES,
  localparam int unsigned LIW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int unsigned LCW = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [LCW-1:0]    nl_i,
  input  logic              in_vld,
  input  logic [LIW-1:0]    in_lane,
  input  logic [LANE_W-1:0] in_val,
  output logic              done_o,
  output logic [VW-1:0]     result_o
);

  logic [VW-1:0] gath_q, res_q;
  logic          fin_q, done_q;
  logic          is_last, single;

  assign is_last = in_vld && (LCW'(in_lane) == nl_i - LCW'(1));
  assign single  = (nl_i == LCW'(1));

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gath_q[g*LANE_W +: LANE_W] <= '0;
      else if (clear_i)
        gath_q[g*LANE_W +: LANE_W] <= '0;
      else if (in_vld && in_lane == LIW'(g))
        gath_q[g*LANE_W +: LANE_W] <= in_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      fin_q  <= 1'b0;
      if (fin_q) begin
        res_q  <= gath_q;
        done_q <= 1'b1;
      end else if (is_last && single) begin
        res_q  <= VW'(in_val);
        done_q <= 1'b1;
      end else if (is_last) begin
        fin_q  <= 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  logic [VW-1:0] used_mask;
  always_comb begin
    used_mask = '0;
    for (int i = 0; i < MAX_LANES; i++)
      if (LCW'(i) < nl_i) used_mask[i*LANE_W +: LANE_W] = '1;
  end

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: the packed result only changes together with done
  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q) || $rose(done_q));

  // R3: lanes outside the selected width read zero at done
  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((res_q & ~used_mask) == '0));

  // R4: the gather step of a multi-lane op completes in the next cycle
  a_r4_gather_step: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> done_q);

endmodule

// File: rtl/simd_lane_seq.sv
module simd_lane_seq #(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned MAX_LANES = 4,
  parameter int unsigned PIPE      = 5,
  parameter int unsigned WSEL_W    = 2,
  localparam int unsigned VW  = LANE_W * MAX_LANES,
  localparam int unsigned LIW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int unsigned LCW = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [VW-1:0]     a_i,
  input  logic [VW-1:0]     b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [VW-1:0]     result_o
);
  import simd_seq_pkg::*;

  logic              accept, iss_vld, iss_op, exit_vld;
  logic [LIW-1:0]    iss_lane, exit_lane;
  logic [LANE_W-1:0] iss_a, iss_b, exit_val;
  logic [LCW-1:0]    nl;

  seq_ctrl #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .WSEL_W(WSEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wsel_i(wsel_i),
    .a_i(a_i), .b_i(b_i), .done_i(done_o), .accept_o(accept), .busy_o(busy_o),
    .nl_o(nl), .iss_vld_o(iss_vld), .iss_lane_o(iss_lane), .iss_op_o(iss_op),
    .iss_a_o(iss_a), .iss_b_o(iss_b)
  );

  lane_pipe #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .PIPE(PIPE)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(iss_vld), .in_lane(iss_lane),
    .in_op(iss_op), .in_a(iss_a), .in_b(iss_b),
    .out_vld(exit_vld), .out_lane(exit_lane), .out_val(exit_val)
  );

  lane_gather #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_gather (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .nl_i(nl),
    .in_vld(exit_vld), .in_lane(exit_lane), .in_val(exit_val),
    .done_o(done_o), .result_o(result_o)
  );

  // Cycle counter kept for the latency property.
  logic [7:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 8'd1;
  end

  // R4: done arrives exactly at the width-dependent latency
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(lat_q) == int'(seq_latency(int'(nl), PIPE))));

  // R6: done only appears while busy
  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

endmodule

// File: tb/tb_simd_lane_seq.sv
`timescale 1ns/1ps
module tb_simd_lane_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  wsel_i = 2'd0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  simd_lane_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wsel_i(wsel_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic int lanes_of(input logic [1:0] ws);
    case (ws)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [63:0] model(input logic op, input logic [1:0] ws,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    int unsigned x, y, z;
    r = '0;
    for (int i = 0; i < lanes_of(ws); i++) begin
      x = int'(a[16*i +: 16]);
      y = int'(b[16*i +: 16]);
      z = op ? (x * y) % 65536 : (x + y) % 65536;
      r[16*i +: 16] = z[15:0];
    end
    return r;
  endfunction

  function automatic int exp_cycles(input logic [1:0] ws);
    int n;
    n = lanes_of(ws);
    return (n == 1) ? 6 : 6 + n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one op; assumes we sit just after a negedge. mode 1 injects starts mid-run
  // and in the done cycle.
  task automatic run_op(input logic op, input logic [1:0] ws,
                        input logic [63:0] a, input logic [63:0] b, input int mode);
    int cyc;
    bit busy_ok;
    logic [63:0] exp;
    exp = model(op, ws, a, b);
    start_i = 1'b1; op_i = op; wsel_i = ws; a_i = a; b_i = b;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; a_i = ~a; b_i = b ^ 64'h5a5a;
    cyc = 0;
    busy_ok = 1'b1;
    while (!done_o && cyc < 40) begin
      if (!busy_o) busy_ok = 1'b0;
      if (mode == 1 && cyc == 3) begin start_i = 1'b1; op_i = ~op; wsel_i = 2'd2; end
      else start_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check(busy_ok && busy_o, "R6", "busy through op", 64'(busy_o), 64'd1);
    check(cyc == exp_cycles(ws), "R4", "latency", 64'(cyc), 64'(exp_cycles(ws)));
    check(result_o == exp, "R2", "lane results", result_o, exp);
    if (ws != 2'd2) check(result_o == exp, "R3", "width and zero lanes", result_o, exp);
    if (mode == 1) begin
      // done and a new start fall in the same cycle: the start must be ignored
      start_i = 1'b1; op_i = ~op; wsel_i = 2'd0;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      check(!busy_o && !done_o, "R7", "start in done cycle ignored",
            {62'd0, busy_o, done_o}, 64'd0);
      for (int k = 0; k < 12; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (done_o || busy_o) break;
      end
      check(!done_o && !busy_o, "R7", "no extra done", {62'd0, busy_o, done_o}, 64'd0);
      check(result_o == exp, "R5", "result held", result_o, exp);
    end else begin
      @(posedge clk);
      @(negedge clk);
      check(!done_o, "R5", "done single cycle", 64'(done_o), 64'd0);
      check(!busy_o, "R6", "busy low after done", 64'(busy_o), 64'd0);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] pats [6];
    pats[0] = 64'h0001_0002_0003_0004;
    pats[1] = 64'hffff_ffff_ffff_ffff;
    pats[2] = 64'h8000_7fff_0100_00ff;
    pats[3] = 64'h1234_5678_9abc_def0;
    pats[4] = 64'h0000_0000_0000_0000;
    pats[5] = 64'hdead_beef_cafe_f00d;

    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && result_o == '0, "R1", "reset state", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4: every opcode and width code against a set of patterns
    for (int op = 0; op < 2; op++)
      for (int ws = 0; ws < 4; ws++)
        for (int p = 0; p < 6; p++)
          run_op(op[0], ws[1:0], pats[p], pats[(p + 1) % 6] ^ {4{16'(p * 4099)}}, 0);

    // R2 near-exhaustive small-value sweep on four lanes
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        run_op(1'(x + y), 2'd2, {16'(x), 16'(x + 1), 16'(7 - x), 16'(x * 3)},
               {16'(y), 16'(y * 5), 16'(y + 9), 16'hfff0 + 16'(y)}, 0);

    // R7 injected starts mid-run and in the done cycle
    for (int ws = 0; ws < 4; ws++)
      run_op(1'b1, ws[1:0], pats[3], pats[2], 1);

    // R8: start offered in the first cycle after done is taken
    run_op(1'b0, 2'd1, pats[0], pats[5], 0);
    run_op(1'b1, 2'd2, pats[5], pats[3], 0);
    check(1'b1, "R8", "back-to-back accepted (latency checked above)", 64'd0, 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule